// File: doc/BRIEF.md
# USB Host Functional State Controller

This block holds the operating state of a USB host controller together with a small control register that software writes and reads back. The controller has four functional states. A hardware reset and a software reset each put it into a different state. After software moves it into the operational state, frame generation is enabled a fixed delay later.

While the controller is suspended, a resume detected on a downstream port moves it to the resume state. The same resume also raises a wakeup request to the host system when software has enabled that feature. A single incoming interrupt request is steered to either a normal interrupt line or a system-management interrupt line, as chosen by a register bit.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure. A write is a single-cycle strobe that is always accepted. A read is a combinational view of the register.

Top module: `hcs_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `state` is 00 (reset), `rd_data` is zero, `sof_en`, `wakeup_req`, `irq_norm` and `irq_smi` are 0, and `root_rst_req` is 1.
- R2: A cycle with `sw_reset` high puts `state` at 11 (suspend) on the next clock. It drops `sof_en` and leaves the wake-connected bit (9), the routing bit (8) and the wake-enable bit (10) unchanged. `sw_reset` takes priority over a write in the same cycle.
- R3: A cycle with `wr_en` high loads `wr_data[7:6]` into the state field and `wr_data[10:8]` into bits 10:8 on the next clock. `rd_data` shows the state in bits 7:6 and those bits in 10:8. All other `rd_data` bits read 0 whatever was written.
- R4: Without a write or software reset, `state` changes by itself only from 11 (suspend) to 01 (resume), on the clock after a cycle with `resume_det` high. In states 00, 01 and 10, `resume_det` leaves `state` unchanged. A write in the same cycle takes priority over the resume.
- R5: After `state` changes to 10 (operational) from another state, `sof_en` rises on the clock edge that samples the second `tick_1ms` pulse seen while `state` is 10. Writing 10 again while already operational does not restart this count.
- R6: When `state` leaves 10, `sof_en` is 0 from that same clock, and the pending start is cancelled. A later entry counts two fresh ticks.
- R7: `wakeup_req` is a one-cycle pulse on the clock after a cycle with `resume_det` high, but only when bit 10 is 1. It never pulses while bit 10 is 0. Bit 10 has no effect on `irq_norm` or `irq_smi`.
- R8: With bit 8 at 0, `irq_norm` follows `irq_src` and `irq_smi` is 0. With bit 8 at 1, `irq_smi` follows `irq_src` and `irq_norm` is 0.
- R9: `root_rst_req` is 1 exactly while `state` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| sw_reset | input | 1 | Software reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| resume_det | input | 1 | Resume detected on a downstream port |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| irq_src | input | 1 | Interrupt request to be routed |
| state | output | 2 | Functional state |
| sof_en | output | 1 | Start-of-frame generation enable |
| root_rst_req | output | 1 | Reset signaling request to the root hub |
| wakeup_req | output | 1 | Wakeup request to the host system |
| irq_norm | output | 1 | Normal bus interrupt |
| irq_smi | output | 1 | System-management interrupt |

## Verification
The assertions check on every cycle that:
- the state holds unless a write, a software reset or a resume while suspended moves it;
- a software reset always lands in suspend;
- `sof_en` is seen only after at least two cycles in the operational state;
- a routed interrupt appears on exactly one line;
- a wakeup pulse always follows a resume.

Only the bench scenarios can show the exact tick count before `sof_en` rises, the cancelling and non-restart cases, the retention of bits across software reset, and the zero readback of unused bits. The bench sweeps every state against every setting of the three control bits and against resume input.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'b00,
    ST_RESUME = 2'b01,
    ST_OPER  = 2'b10,
    ST_SUSP  = 2'b11
  } hcs_state_e;

  localparam int REG_W     = 32;
  localparam int STATE_LSB = 6;
  localparam int BIT_ROUTE = 8;
  localparam int BIT_WCONN = 9;
  localparam int BIT_WEN   = 10;
endpackage

// File: rtl/hcs_state_fsm.sv
module hcs_state_fsm
  import hcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_reset,
  input  logic       wr_en,
  input  logic [1:0] wr_state,
  input  logic       resume_det,
  output hcs_state_e state
);
  hcs_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    if (sw_reset)
      state_nxt = ST_SUSP;
    else if (wr_en)
      state_nxt = hcs_state_e'(wr_state);
    else if (resume_det && state == ST_SUSP)
      state_nxt = ST_RESUME;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_nxt;
  end

  // R4: no self-initiated change outside suspend
  assert_hold_outside_susp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_reset && !wr_en && state != ST_SUSP) |=> $stable(state));
  // R2: software reset lands in suspend
  assert_swrst_susp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> state == ST_SUSP);
endmodule

// File: rtl/hcs_cfg_bits.sv
module hcs_cfg_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_reset,
  input  logic wr_en,
  input  logic wen_in,
  input  logic wconn_in,
  input  logic route_in,
  input  logic resume_det,
  output logic wake_en,
  output logic wake_conn,
  output logic route_smi,
  output logic wakeup_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_en    <= 1'b0;
      wake_conn  <= 1'b0;
      route_smi  <= 1'b0;
      wakeup_req <= 1'b0;
    end else begin
      if (wr_en && !sw_reset) begin
        wake_en   <= wen_in;
        wake_conn <= wconn_in;
        route_smi <= route_in;
      end
      wakeup_req <= wake_en && resume_det;
    end
  end

  // R7: a wakeup pulse is always preceded by a resume
  assert_wake_after_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_req |-> $past(resume_det));
endmodule

// File: rtl/hcs_sof_timer.sv
module hcs_sof_timer #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_oper,
  input  logic tick_1ms,
  output logic sof_en
);
  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_oper)
      cnt <= '0;
    else if (tick_1ms && cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end

  assign sof_en = in_oper && (cnt == CNT_MAX);
endmodule

// File: rtl/hcs_top.sv
module hcs_top
  import hcs_pkg::*;
#(
  parameter int SOF_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_reset,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  input  logic                resume_det,
  input  logic                tick_1ms,
  input  logic                irq_src,
  output logic [1:0]          state,
  output logic                sof_en,
  output logic                root_rst_req,
  output logic                wakeup_req,
  output logic                irq_norm,
  output logic                irq_smi
);
  hcs_state_e st;
  logic wake_en, wake_conn, route_smi;

  hcs_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_en(wr_en),
    .wr_state(wr_data[STATE_LSB +: 2]), .resume_det(resume_det), .state(st)
  );

  hcs_cfg_bits u_cfg (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_en(wr_en),
    .wen_in(wr_data[BIT_WEN]), .wconn_in(wr_data[BIT_WCONN]),
    .route_in(wr_data[BIT_ROUTE]), .resume_det(resume_det),
    .wake_en(wake_en), .wake_conn(wake_conn), .route_smi(route_smi),
    .wakeup_req(wakeup_req)
  );

  hcs_sof_timer #(.TICKS(SOF_TICKS)) u_sof (
    .clk(clk), .rst_n(rst_n), .in_oper(st == ST_OPER),
    .tick_1ms(tick_1ms), .sof_en(sof_en)
  );

  always_comb begin
    rd_data = '0;
    rd_data[STATE_LSB +: 2] = st;
    rd_data[BIT_ROUTE]      = route_smi;
    rd_data[BIT_WCONN]      = wake_conn;
    rd_data[BIT_WEN]        = wake_en;
  end

  assign state        = st;
  assign root_rst_req = (st == ST_RESET);
  assign irq_norm     = irq_src && !route_smi;
  assign irq_smi      = irq_src && route_smi;

  // R5: frames never start without two cycles in the operational state
  assert_sof_needs_oper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_en |-> (st == ST_OPER && $past(st) == ST_OPER));
  // R8: a routed interrupt appears on exactly one line
  assert_irq_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src |-> (irq_norm != irq_smi));
  // R9: reset signaling requested only in the reset state
  assert_rootrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    root_rst_req |-> (rd_data[STATE_LSB +: 2] == 2'b00));
endmodule

// File: tb/tb_hcs_top.sv
module tb_hcs_top;
  logic clk = 1'b0;
  logic rst_n, sw_reset, wr_en, resume_det, tick_1ms, irq_src;
  logic [31:0] wr_data, rd_data;
  logic [1:0] state;
  logic sof_en, root_rst_req, wakeup_req, irq_norm, irq_smi;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hcs_top dut (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .resume_det(resume_det),
    .tick_1ms(tick_1ms), .irq_src(irq_src), .state(state), .sof_en(sof_en),
    .root_rst_req(root_rst_req), .wakeup_req(wakeup_req),
    .irq_norm(irq_norm), .irq_smi(irq_smi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] regval(input logic [1:0] st, input logic [2:0] b);
    return (32'(b) << 8) | (32'(st) << 6);
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick();
    tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; sw_reset = 0; wr_en = 0; wr_data = '0;
    resume_det = 0; tick_1ms = 0; irq_src = 0;
    step(); step();
    chk("R1 state in reset", 32'(state), 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 root_rst_req", 32'(root_rst_req), 1);
    rst_n = 1; step();
    chk("R1 state after reset", 32'(state), 0);
    chk("R1 sof_en", 32'(sof_en), 0);
    chk("R1 wakeup_req", 32'(wakeup_req), 0);
    chk("R1 irq lines", {30'b0, irq_norm, irq_smi}, 0);

    // R3 R9 sweep: every state with every control-bit setting, junk elsewhere
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 8; b++) begin
        wr(32'hFFFF_F83F | regval(2'(s), 3'(b)) & 32'h0000_07C0 | (32'(b) << 8) | (32'(s) << 6));
        wr(regval(2'(s), 3'(b)) | 32'hFFFF_F83F);
        chk("R3 readback", rd_data, regval(2'(s), 3'(b)));
        chk("R9 root_rst_req", 32'(root_rst_req), (s == 0) ? 1 : 0);
      end

    // R4 R7 sweep: resume in every state, wake enable on and off
    for (int s = 0; s < 4; s++)
      for (int we = 0; we < 2; we++) begin
        wr(regval(2'(s), we ? 3'b100 : 3'b000));
        resume_det = 1; step(); resume_det = 0;
        chk("R4 resume response", 32'(state), (s == 3) ? 1 : s);
        chk("R7 wakeup pulse", 32'(wakeup_req), 32'(we));
        step();
        chk("R7 pulse one cycle", 32'(wakeup_req), 0);
      end
    // R4 write wins over resume in suspend
    wr(regval(2'b11, 3'b000));
    resume_det = 1; wr(regval(2'b10, 3'b000)); resume_det = 0;
    chk("R4 write priority", 32'(state), 2);

    // R2 software reset from every state, bits kept, over a write
    for (int s = 0; s < 4; s++) begin
      wr(regval(2'(s), 3'b111));
      sw_reset = 1; wr_en = 1; wr_data = regval(2'b00, 3'b000); step();
      sw_reset = 0; wr_en = 0;
      chk("R2 swreset readback", rd_data, regval(2'b11, 3'b111));
      chk("R2 sof_en", 32'(sof_en), 0);
    end

    // R5 two ticks while operational
    wr(regval(2'b11, 3'b000));
    tick_1ms = 1; wr(regval(2'b10, 3'b000)); tick_1ms = 0;
    chk("R5 no sof at entry", 32'(sof_en), 0);
    step(); step();
    tick();
    chk("R5 one tick", 32'(sof_en), 0);
    step();
    tick();
    chk("R5 second tick", 32'(sof_en), 1);
    // R5 rewrite operational keeps sof
    wr(regval(2'b10, 3'b000));
    chk("R5 rewrite keeps sof", 32'(sof_en), 1);
    // R6 leaving drops sof
    wr(regval(2'b01, 3'b000));
    chk("R6 leave drops sof", 32'(sof_en), 0);
    // R5 rewrite during pending does not restart
    wr(regval(2'b10, 3'b000));
    tick();
    wr(regval(2'b10, 3'b000));
    tick();
    chk("R5 no restart on rewrite", 32'(sof_en), 1);
    // R6 cancel pending
    wr(regval(2'b11, 3'b000));
    wr(regval(2'b10, 3'b000));
    tick();
    wr(regval(2'b00, 3'b000));
    wr(regval(2'b10, 3'b000));
    tick();
    chk("R6 pending cancelled", 32'(sof_en), 0);
    tick();
    chk("R6 fresh count", 32'(sof_en), 1);
    sw_reset = 1; step(); sw_reset = 0;
    chk("R6 swreset drops sof", 32'(sof_en), 0);

    // R8 routing sweep, R7 wake enable no effect on irq
    for (int r = 0; r < 2; r++)
      for (int we = 0; we < 2; we++)
        for (int i = 0; i < 2; i++) begin
          wr(regval(2'b10, 3'(we * 4 + r)));
          irq_src = 1'(i); #1;
          chk("R8 irq_norm", 32'(irq_norm), (i == 1 && r == 0) ? 1 : 0);
          chk("R8 irq_smi", 32'(irq_smi), (i == 1 && r == 1) ? 1 : 0);
          irq_src = 0;
        end

    // R1 hardware reset clears kept bits
    wr(regval(2'b10, 3'b111));
    rst_n = 0; step(); rst_n = 1; step();
    chk("R1 hw reset clears", rd_data, 0);
    chk("R1 root reset again", 32'(root_rst_req), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule